// File: doc/BRIEF.md
# Multiplexed Host Bus Slave with Interrupt Collector

This block connects a bus controller's register and message space to an 8-bit host processor whose address and data share one set of lines. The host puts an address on the bus with the address strobe high. The block captures it when that strobe falls. The host then drives an active-low read or write strobe, qualified by an active-low chip select, to reach one byte of a 256-byte space. That space holds eleven control bytes, fourteen channel descriptor sets of eight bytes each, and 128 bytes of general-purpose message storage.

The block also gathers six interrupt causes into one active-low interrupt pin. Five causes come in as single-cycle pulses from the protocol logic. The sixth is raised by reset itself, so the host can tell that an unexpected reset (for example a glitch on the reset line) has happened. Flags are cleared by writing ones. The pin may be treated as level or edge sensitive. When a host write clears one enabled cause while another enabled cause stays pending, the pin is released for the whole write strobe and then asserted again. This gives an edge-triggered host a fresh falling edge.

The pins are assumed to be synchronous to the block clock. The bidirectional bus is split into an input, an output and an output enable.

Top module: `vhost_bus`

## Requirements
- R1: The byte address is taken from `ad_in` on the falling edge of `ale`. Later changes on `ad_in` do not change which byte the following read or write strobe reaches.
- R2: `ad_oe` is 1 only while `cs_n` and `rd_n` are both 0. During a read, `ad_out` carries the addressed byte.
- R3: A write stores the data byte present during the strobe. It takes effect when `wr_n` rises while `cs_n` is 0. A strobe with `cs_n` at 1 changes nothing.
- R4: Bytes 0x00-0x0A (control), 0x10-0x7F (channel sets) and 0x80-0xFF (storage) can be read and written. Bytes 0x0B-0x0F read as 0x00 and ignore writes.
- R5: The interrupt flag byte is at 0x04, with bits 5:0 holding causes 0-5 and bits 7:6 reading 0. Writing a 1 clears that flag, and writing a 0 leaves it unchanged.
- R6: A one-cycle pulse on `src_evt[i]` (i = 0..4) sets flag bit i.
- R7: After reset, flag byte 0x04 reads 0x20 (cause 5, the reset event), mask byte 0x05 reads 0x00, and `irq_n` is 1.
- R8: The mask byte is at 0x05, with bit i enabling cause i. Outside the case in R9, `irq_n` is 0 exactly when some flag and its mask bit are both 1.
- R9: While a selected write strobe to 0x04 carries data that clears at least one enabled pending flag and leaves at least one other enabled pending flag, `irq_n` is 1. It returns to 0 after the strobe ends.
- R10: A write to 0x04 that clears every enabled pending flag keeps `irq_n` at 0 during the strobe, and `irq_n` is 1 after the write takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale | input | 1 | Address strobe, address captured when it falls |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| ad_in | input | 8 | Multiplexed address/data from host |
| ad_out | output | 8 | Read data to host |
| ad_oe | output | 1 | Drive enable for the shared bus |
| src_evt | input | 5 | Interrupt cause pulses 0 to 4 |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A wrong captured address shows up at the very next strobe: the byte read back comes from the wrong location, or a different location keeps its old value. A wrong flag or mask state reaches `irq_n` in the cycle after the write or pulse that caused it. The flag byte reads back wrong on the next read cycle. The release during a partial clear can only be seen while the write strobe is low, so the bench samples `irq_n` in the middle of the strobe and again after it. This catches a missing pulse, a pulse on a full clear, and a pulse that outlasts the write.

// File: rtl/vhost_bus.sv
module vhost_bus #(
  parameter int DW         = 8,
  parameter int AW         = 8,
  parameter int NSRC       = 6,
  parameter int CTRL_N     = 11,
  parameter int CHAN_BASE  = 16,
  parameter int CHAN_N     = 14,
  parameter int CHAN_BYTES = 8,
  parameter int RAM_BASE   = 128,
  parameter int FLAG_ADDR  = 4,
  parameter int MASK_ADDR  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [NSRC-2:0] src_evt,
  output logic          irq_n
);
  localparam int DEPTH    = 1 << AW;
  localparam int CHAN_END = CHAN_BASE + CHAN_N * CHAN_BYTES;

  logic [DW-1:0]   mem [DEPTH];
  logic [AW-1:0]   addr;
  logic [DW-1:0]   ad_d;
  logic            ale_d, wr_d, cs_d;
  logic [NSRC-1:0] flags, mask, pend, clr, hits, keep;
  logic            commit, at_flag, wr_live, pulse;

  function automatic logic mapped(input logic [AW-1:0] a);
    int v;
    v = int'(a);
    return (v < CTRL_N) || (v >= CHAN_BASE && v < CHAN_END) || (v >= RAM_BASE);
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ale_d <= 1'b0;
      wr_d  <= 1'b1;
      cs_d  <= 1'b1;
      ad_d  <= '0;
    end else begin
      ale_d <= ale;
      wr_d  <= wr_n;
      cs_d  <= cs_n;
      ad_d  <= ad_in;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) addr <= '0;
    else if (ale_d && !ale) addr <= ad_d[AW-1:0];

  assign commit  = !wr_d && wr_n && !cs_d;
  assign at_flag = (int'(addr) == FLAG_ADDR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit && mapped(addr)) begin
      mem[addr] <= ad_d;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mask <= '0;
    else if (commit && int'(addr) == MASK_ADDR) mask <= ad_d[NSRC-1:0];

  assign clr = (commit && at_flag) ? ad_d[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= NSRC'(1) << (NSRC - 1);
    else        flags <= (flags & ~clr) | {1'b0, src_evt};

  always_comb begin
    ad_out = '0;
    if (at_flag)                         ad_out[NSRC-1:0] = flags;
    else if (int'(addr) == MASK_ADDR)    ad_out[NSRC-1:0] = mask;
    else if (mapped(addr))               ad_out = mem[addr];
  end

  assign ad_oe = !cs_n && !rd_n;

  assign pend    = flags & mask;
  assign wr_live = !cs_n && !wr_n && at_flag;
  assign hits    = pend & ad_in[NSRC-1:0];
  assign keep    = pend & ~ad_in[NSRC-1:0];
  assign pulse   = wr_live && (|hits) && (|keep);
  assign irq_n   = !(|pend) || pulse;

  // R3
  mem_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && mapped(addr)) |=> mem[$past(addr)] == $past(ad_d));

  // R4
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && !mapped(addr) && !at_flag && int'(addr) != MASK_ADDR) |-> ad_out == '0);

  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && at_flag && src_evt == '0) |=> (flags & $past(ad_d[NSRC-1:0])) == '0);

  // R6
  src_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt != '0) |=> (flags[NSRC-2:0] & $past(src_evt)) == $past(src_evt));

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (|(flags & mask)));

  // R9
  release_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n && (|(flags & mask))) |-> (!wr_n && !cs_n));
endmodule

// File: tb/test_vhost_bus.sv
module test_vhost_bus;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ale = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] ad_in = '0;
  logic [7:0] ad_out;
  logic       ad_oe;
  logic [4:0] src_evt = '0;
  logic       irq_n;

  always #2 clk = ~clk;

  vhost_bus i_vhost_bus (
    .clk(clk), .rst_n(rst_n), .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .src_evt(src_evt), .irq_n(irq_n)
  );

  int    checks = 0, fails = 0;
  bit    done = 0;
  int    exp_q[$];
  string tag_q[$];
  int    act_val;
  event  mon_ev;

  initial forever begin
    @(mon_ev);
    if (exp_q.size() != 0) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (act_val != e) begin
        fails++;
        $display("FAIL %s: actual %0h expected %0h", t, act_val, e);
      end
    end
  end

  task automatic expect_val(input string t, input int e, input int a);
    exp_q.push_back(e);
    tag_q.push_back(t);
    act_val = a;
    ->mon_ev;
    #0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input bit sel,
                           input bit mid_chk, input int mid_exp, input string t);
    @(negedge clk) cs_n = !sel; ale = 1'b1; ad_in = a;
    @(negedge clk) ale = 1'b0;
    @(negedge clk) ad_in = d;
    @(negedge clk) wr_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    if (mid_chk) expect_val(t, mid_exp, int'(irq_n));
    wr_n = 1'b1;
    @(negedge clk) cs_n = 1'b1; ad_in = 8'h00;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [7:0] a, input int e, input string t);
    @(negedge clk) cs_n = 1'b0; ale = 1'b1; ad_in = a;
    @(negedge clk) ale = 1'b0;
    @(negedge clk) ad_in = ~a;
    rd_n = 1'b0;
    @(negedge clk);
    expect_val({t, " oe"}, 1, int'(ad_oe));
    expect_val(t, e, int'(ad_out));
    rd_n = 1'b1;
    @(negedge clk);
    expect_val({t, " oe off"}, 0, int'(ad_oe));
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_src(input logic [4:0] v);
    @(negedge clk) src_evt = v;
    @(negedge clk) src_evt = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_val("R7 irq after reset", 1, int'(irq_n));
    expect_val("R2 oe idle", 0, int'(ad_oe));
    bus_read(8'h04, 8'h20, "R7 flag after reset");
    bus_read(8'h05, 8'h00, "R7 mask after reset");

    bus_write(8'h00, 8'hA5, 1, 0, 0, "");
    bus_read(8'h00, 8'hA5, "R3 control write");
    bus_write(8'h83, 8'h11, 1, 0, 0, "");
    bus_write(8'h82, 8'h3C, 1, 0, 0, "");
    bus_read(8'h82, 8'h3C, "R1 latched address");
    bus_read(8'h83, 8'h11, "R1 neighbour intact");
    bus_write(8'h83, 8'h99, 0, 0, 0, "");
    bus_read(8'h83, 8'h11, "R3 unselected write ignored");
    bus_write(8'h7F, 8'h5A, 1, 0, 0, "");
    bus_write(8'hFF, 8'hC3, 1, 0, 0, "");
    bus_write(8'h10, 8'h01, 1, 0, 0, "");
    bus_write(8'h0C, 8'h77, 1, 0, 0, "");
    bus_read(8'h7F, 8'h5A, "R4 channel last byte");
    bus_read(8'hFF, 8'hC3, "R4 storage last byte");
    bus_read(8'h10, 8'h01, "R4 channel first byte");
    bus_read(8'h0C, 8'h00, "R4 gap reads zero");

    bus_write(8'h04, 8'h00, 1, 0, 0, "");
    bus_read(8'h04, 8'h20, "R5 zero write keeps flags");
    bus_write(8'h04, 8'hE0, 1, 0, 0, "");
    bus_read(8'h04, 8'h00, "R5 one clears flag");

    pulse_src(5'b00010);
    pulse_src(5'b01000);
    bus_read(8'h04, 8'h0A, "R6 sources set flags");
    expect_val("R8 masked off", 1, int'(irq_n));
    bus_write(8'h05, 8'h02, 1, 0, 0, "");
    expect_val("R8 enabled cause", 0, int'(irq_n));
    bus_write(8'h05, 8'h0A, 1, 0, 0, "");
    bus_read(8'h05, 8'h0A, "R8 mask readback");

    bus_write(8'h04, 8'h02, 1, 1, 1, "R9 release during strobe");
    expect_val("R9 reasserted after strobe", 0, int'(irq_n));
    bus_read(8'h04, 8'h08, "R9 remaining flag");

    bus_write(8'h04, 8'h08, 1, 1, 0, "R10 no release on full clear");
    expect_val("R10 idle after clear", 1, int'(irq_n));

    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule